// File: doc/BRIEF.md
# SPI Memory Status and Write-Protect Controller

This block is the command front end of a small serial nonvolatile memory. It watches an SPI mode 0 link (data captured on the rising clock edge, driven on the falling edge, most significant bit first). It decodes four status-related instructions: latch write enable, read status, write status and read identification. It keeps the protection state of the part, which is a two-bit block-protect level and a protect-enable bit. Writing that state starts a self-timed internal write cycle. The cycle lasts a parameterised number of system clocks.

The array and its erase/program machinery are not part of this block. An array write is represented only by an address input and a combinational grant output. The grant tells the array logic whether the addressed location lies outside the sectors that the current protect level locks. The 128 KB array is treated as four 32 KB sectors. The block-protect level can lock the top sector, the top two sectors, or all four.

All SPI pins and the write-protect pin are synchronised into the system clock domain. An instruction takes effect when chip select is released, and only if the release falls on a whole-byte boundary.

Top module: `spi_status_ctrl`

## Requirements
- R1: A read-status instruction (opcode 0x05) returns the status byte on every byte that follows the opcode, MSB first. When idle, the byte is: bit 0 busy (0), bit 1 write-enable latch, bit 2 level bit 0, bit 3 level bit 1, bits 6..4 zero, bit 7 protect-enable. After reset the byte is 0x00.
- R2: While the internal write cycle runs, a read-status instruction returns 0xFF.
- R3: Opcode 0x06 sets the write-enable latch. It acts only when chip select rises after a whole number of bytes. If chip select rises mid-byte, nothing changes.
- R4: Opcode 0x01 followed by a data byte is accepted only when the write-enable latch is set. It copies data bits 2, 3 and 7 into the level bits and the protect-enable bit, and starts the internal write cycle. Without the latch, nothing changes.
- R5: When wp_n is low and protect-enable is 1, a status write is refused and the status is left unchanged. With wp_n high, the same write is accepted.
- R6: After an accepted status write, the busy condition lasts WR_CYCLES system clocks and then ends on its own.
- R7: During the internal write cycle, every instruction except read status is ignored. In particular, read identification returns 0x00 bytes.
- R8: The write-enable latch is cleared when the internal write cycle completes.
- R9: Opcode 0x15 returns the manufacturer byte 0x1F, then the device byte DEV_CODE (default 0x60).
- R10: arr_write_ok is 0 for locked addresses. Level 0 locks nothing. Level 1 locks 0x18000..0x1FFFF. Level 2 locks 0x10000..0x1FFFF. Level 3 locks every address.
- R11: The write-protect pin has no effect on arr_write_ok. Locked sectors stay locked and unlocked sectors stay writable whatever wp_n is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_addr | input | ADDR_W | Array address whose write permission is queried |
| arr_write_ok | output | 1 | 1 when the addressed location may be written |

## Verification
The bench builds the block with ADDR_W at 17, so the real sector boundaries at 0x10000 and 0x18000 can be probed exactly. WR_CYCLES is set to 800 system clocks against an SPI bit time of 16 clocks. This is long enough that a status read and a whole identification read both fit inside one busy window, which makes the all-ones status and the ignored instructions observable. It is also short enough that every protect level can be written and checked in turn. The default opcodes and device code are kept, so the identification bytes are 0x1F and 0x60.

// File: rtl/spi_stat_pkg.sv
// Package: shared constants and the idle status byte layout for the
// SPI status / write-protect controller.
package spi_stat_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] MFR_CODE = 8'h1F;

    // Assemble the idle status byte; busy overrides to all ones elsewhere.
    function automatic logic [BYTE_W-1:0] idle_status(
        input logic       pen,
        input logic [1:0] lvl,
        input logic       wel
    );
        return {pen, 3'b000, lvl, wel, 1'b0};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: two-flop synchroniser for a group of asynchronous pins.
// Assumes: every pin is independent; RST gives each pin's reset level.
module spi_pin_sync #(
    parameter int             W   = 4,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        // Two register stages per pin to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta    <= RST[g];
                sync[g] <= RST[g];
            end else begin
                meta    <= raw[g];
                sync[g] <= meta;
            end
        end
    end
endmodule

// File: rtl/spi_byte_shifter.sv
// Module: SPI mode 0 byte engine. It captures on rising SCK, shifts out on
// falling SCK (MSB first), pulses byte_done after each 8th bit and tracks
// the byte index inside the frame.
// Assumes: inputs are already synchronised; SCK is slow against clk.
module spi_byte_shifter
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [1:0]        byte_idx,
    output logic              on_boundary,
    output logic              cs_rise,
    output logic              miso
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              sck_q, cs_q;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] tx_sh;
    logic              sck_rise, sck_fall;

    assign sck_rise    = sck & ~sck_q & ~cs_n;
    assign sck_fall    = ~sck & sck_q & ~cs_n;
    assign cs_rise     = cs_n & ~cs_q;
    assign on_boundary = (bit_cnt == '0);
    assign miso        = tx_sh[BYTE_W-1];

    // Edge history of SCK and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Receive shift, bit counter, byte strobe and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (cs_n) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else begin
                if (sck_rise) begin
                    rx_byte <= {rx_byte[BYTE_W-2:0], mosi};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_W'(BYTE_W-1))
                        byte_done <= 1'b1;
                end
                if (byte_done && byte_idx != 2'd3)
                    byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // Transmit register: load at byte end, shift on falls inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (cs_n) begin
            tx_sh <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_data;
        end else if (sck_fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_lock_decode.sv
// Module: maps the two-bit protect level and an address to a lock flag.
// Assumes: the array is four equal sectors addressed by the top two bits.
module spi_lock_decode #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    logic [1:0] sector;
    assign sector = addr[ADDR_W-1 -: 2];

    // Compare the addressed sector with the protected range of the level.
    always_comb begin
        unique case (level)
            2'd0:    locked = 1'b0;
            2'd1:    locked = (sector == 2'd3);
            2'd2:    locked = sector[1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_status_ctrl.sv
// Module: top of the SPI status / write-protect controller. It decodes the
// instructions, keeps the write-enable latch and protect state, times the
// internal write cycle and answers array write-permission queries.
// Assumes: SPI mode 0, SCK at most clk/8, instructions run at CS release.
module spi_status_ctrl
    import spi_stat_pkg::*;
#(
    parameter int          ADDR_W    = 17,
    parameter int          WR_CYCLES = 1000,
    parameter logic [7:0]  OP_WREN   = 8'h06,
    parameter logic [7:0]  OP_RDSR   = 8'h05,
    parameter logic [7:0]  OP_WRSR   = 8'h01,
    parameter logic [7:0]  OP_RDID   = 8'h15,
    parameter logic [7:0]  DEV_CODE  = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_write_ok
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [3:0]        pins_s;
    logic              sck_s, cs_s, mosi_s, wp_s;
    logic              byte_done, on_boundary, cs_rise, locked;
    logic [BYTE_W-1:0] rx_byte, tx_data, status_byte, op_now;
    logic [BYTE_W-1:0] opcode_q, wr_data_q;
    logic [1:0]        byte_idx, level;
    logic              wel, pen, busy, hw_prot, exec;
    logic [CNT_W-1:0]  wr_cnt;

    spi_pin_sync #(.W(4), .RST(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw({wp_n, spi_cs_n, spi_sck, spi_mosi}),
        .sync(pins_s)
    );
    assign {wp_s, cs_s, sck_s, mosi_s} = pins_s;

    spi_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sck(sck_s), .cs_n(cs_s), .mosi(mosi_s),
        .tx_load(byte_done), .tx_data(tx_data),
        .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
        .on_boundary(on_boundary), .cs_rise(cs_rise), .miso(spi_miso)
    );

    spi_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
        .level(level), .addr(arr_addr), .locked(locked)
    );
    assign arr_write_ok = ~locked;

    assign busy        = (wr_cnt != '0);
    assign hw_prot     = ~wp_s & pen;
    assign status_byte = busy ? '1 : idle_status(pen, level, wel);
    assign op_now      = (byte_idx == 2'd0) ? rx_byte : opcode_q;
    assign exec        = cs_rise & on_boundary & ~busy & (byte_idx != 2'd0);

    // Choose the next byte to shift out from the current instruction.
    always_comb begin
        tx_data = '0;
        if (op_now == OP_RDSR)
            tx_data = status_byte;
        else if (op_now == OP_RDID && !busy) begin
            if (byte_idx == 2'd0)      tx_data = MFR_CODE;
            else if (byte_idx == 2'd1) tx_data = DEV_CODE;
        end
    end

    // Capture the opcode and the first data byte of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q  <= '0;
            wr_data_q <= '0;
        end else if (byte_done) begin
            if (byte_idx == 2'd0) opcode_q  <= rx_byte;
            if (byte_idx == 2'd1) wr_data_q <= rx_byte;
        end
    end

    // Protect state, write-enable latch and self-timed write counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel    <= 1'b0;
            level  <= '0;
            pen    <= 1'b0;
            wr_cnt <= '0;
        end else if (busy) begin
            wr_cnt <= wr_cnt - 1'b1;
            if (wr_cnt == CNT_W'(1))
                wel <= 1'b0;
        end else if (exec) begin
            if (opcode_q == OP_WREN)
                wel <= 1'b1;
            else if (opcode_q == OP_WRSR && byte_idx >= 2'd2 && wel && !hw_prot) begin
                level  <= wr_data_q[3:2];
                pen    <= wr_data_q[7];
                wr_cnt <= CNT_W'(WR_CYCLES);
            end
        end
    end

    // R8: the latch is already clear in the cycle busy drops.
    assert_wel_clear_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R4: a write cycle only ever starts from a set latch.
    assert_start_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R7: protect state is frozen for the whole write cycle.
    assert_state_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({level, pen}));

    // R5: a release under hardware protection never starts a write cycle.
    assert_hw_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && hw_prot && !busy) |=> (!busy && $stable({level, pen})));

    // R10: the top level denies every array write.
    assert_all_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'd3) |-> !arr_write_ok);

    // R6: busy never stays on without the counter moving down.
    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> (wr_cnt < $past(wr_cnt)));
endmodule

// File: tb/sim_spi_status_ctrl.sv
module sim_spi_status_ctrl;
    localparam int AW   = 17;
    localparam int WRC  = 800;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic miso, ok;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    spi_status_ctrl #(.ADDR_W(AW), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n),
        .arr_addr(addr), .arr_write_ok(ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_low(); xfer_bits(op, 8, d); cs_high();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] b1);
        logic [7:0] d;
        cs_low(); xfer_bits(op, 8, d); xfer_bits(b1, 8, d); cs_high();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        cs_low(); xfer_bits(8'h05, 8, d); xfer_bits(8'h00, 8, s); cs_high();
    endtask

    task automatic rd_id(output logic [7:0] m, output logic [7:0] dv);
        logic [7:0] d;
        cs_low(); xfer_bits(8'h15, 8, d); xfer_bits(8'h00, 8, m);
        xfer_bits(8'h00, 8, dv); cs_high();
    endtask

    task automatic probe(input string req, input int a, input int exp);
        addr = AW'(a);
        @(negedge clk);
        check(req, int'(ok), exp);
    endtask

    task automatic t_reset();
        logic [7:0] s, s2;
        check("R1 reset miso", int'(miso), 0);
        probe("R10 level0 top", 'h1FFFF, 1);
        cs_low();
        xfer_bits(8'h05, 8, s);
        xfer_bits(8'h00, 8, s);
        xfer_bits(8'h00, 8, s2);
        cs_high();
        check("R1 reset status", s, 8'h00);
        check("R1 repeated status", s2, 8'h00);
    endtask

    task automatic t_no_wel_and_abort();
        logic [7:0] s, d;
        cmd2(8'h01, 8'h8C);
        rd_status(s);
        check("R4 write without latch", s, 8'h00);
        cs_low(); xfer_bits(8'h06, 4, d); cs_high();
        rd_status(s);
        check("R3 aborted enable", s, 8'h00);
        cs_low(); xfer_bits(8'h06, 8, d); xfer_bits(8'h00, 3, d); cs_high();
        rd_status(s);
        check("R3 enable with trailing bits", s, 8'h00);
        cmd1(8'h06);
        rd_status(s);
        check("R3 enable sets latch", s, 8'h02);
    endtask

    task automatic t_id();
        logic [7:0] m, dv;
        rd_id(m, dv);
        check("R9 manufacturer byte", m, 8'h1F);
        check("R9 device byte", dv, 8'h60);
    endtask

    task automatic t_write_cycle();
        logic [7:0] s, m, dv;
        cmd2(8'h01, 8'hFF);
        rd_status(s);
        check("R2 busy status", s, 8'hFF);
        rd_id(m, dv);
        check("R7 id ignored mfr", m, 8'h00);
        check("R7 id ignored dev", dv, 8'h00);
        repeat (WRC) @(negedge clk);
        rd_status(s);
        check("R6 R8 R4 after cycle", s, 8'h8C);
        probe("R10 level3 low", 'h00000, 0);
        probe("R10 level3 top", 'h1FFFF, 0);
    endtask

    task automatic t_hw_protect();
        logic [7:0] s;
        wp_n = 1'b0;
        cmd1(8'h06);
        rd_status(s);
        check("R5 enable under hw protect", s, 8'h8E);
        cmd2(8'h01, 8'h04);
        repeat (WRC) @(negedge clk);
        rd_status(s);
        check("R5 refused write", s, 8'h8E);
        probe("R11 level3 with pin low", 'h00000, 0);
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        cmd2(8'h01, 8'h04);
        repeat (WRC + 100) @(negedge clk);
        rd_status(s);
        check("R5 accepted with pin high", s, 8'h04);
    endtask

    task automatic t_levels();
        logic [7:0] s;
        probe("R10 level1 top quarter", 'h18000, 0);
        probe("R10 level1 below", 'h17FFF, 1);
        probe("R10 level1 base", 'h00000, 1);
        cmd1(8'h06); cmd2(8'h01, 8'h08);
        repeat (WRC + 100) @(negedge clk);
        rd_status(s);
        check("R1 level2 status", s, 8'h08);
        probe("R10 level2 start", 'h10000, 0);
        probe("R10 level2 below", 'h0FFFF, 1);
        cmd1(8'h06); cmd2(8'h01, 8'h80);
        repeat (WRC + 100) @(negedge clk);
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        probe("R11 level0 pin low base", 'h00000, 1);
        probe("R11 level0 pin low top", 'h1FFFF, 1);
        cmd1(8'h06); cmd2(8'h01, 8'h0C);
        repeat (WRC) @(negedge clk);
        rd_status(s);
        check("R5 refused keeps state", s, 8'h82);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_wel_and_abort();
        t_id();
        t_write_cycle();
        t_hw_protect();
        t_levels();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule